// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This block keeps the sticky event flags of an I2C master controller and turns them into one interrupt line and two DMA request lines. Neighbouring logic reports events through a vector of one-cycle set pulses, one per event position. Each pulse sets the matching stored flag, and the flag stays set until software retires it. A 5-bit enable register selects which of the low flags can raise the interrupt.

Software reaches the block through a plain 16-bit register port. It has one write strobe, one read strobe and a byte address offset, and the read data is registered. Reading the vector register returns a code for the lowest pending enabled event and retires that single event in the same access. A DMA control register sends the receive-ready and transmit-ready flags out as DMA requests. Turning on either DMA channel also switches off the interrupt enable of the matching ready flag.

Register offsets: enable at 0x0, status at 0x2, vector at 0x4, DMA control at 0x6. Any other offset reads as zero, and writes to it have no effect.

Top module: `irq_status_vector`

## Requirements
- R1: While reset is high and at the first edge after it, the status, enable and DMA control registers are zero, irq_o, rx_dreq_o and tx_dreq_o are low, and bus_rdata is zero.
- R2: A 1 on evt_set[k] at a clock edge sets stored status bit k when k is one of 1 (no-acknowledge), 2 (access-ready), 3 (receive-ready), 4 (transmit-ready), 9 (addressed-as-slave), 10 (transmit underflow), 11 (receive overrun) or 15 (single-byte data). Pulses at any other position are ignored. A set bit stays set until a vector read clears it.
- R3: A read strobe latches the selected register into bus_rdata at that clock edge. A read of offset 0x2 returns the stored status with bus_busy copied live into bit 12. Bit 12 is not stored, and a status read clears nothing.
- R4: A write to offset 0x0 keeps bits 4:0 of the data as the enable mask. A read of 0x0 returns the mask with bits 15:5 at zero.
- R5: irq_o is high exactly when some status bit among 4:0 is set and its enable bit is set.
- R6: A read of offset 0x4 returns one plus the index of the lowest bit set in both status[4:0] and the enable mask, or zero if there is none. In the same edge it clears that one status bit and leaves all others.
- R7: When a set pulse and a vector-read clear hit the same status bit in the same cycle, the bit ends up set.
- R8: A write to offset 0x6 keeps only bit 15 (receive DMA enable) and bit 7 (transmit DMA enable). A read of 0x6 returns them with all other bits zero.
- R9: A write to 0x6 with bit 15 set clears enable bit 3. A write with bit 7 set clears enable bit 4. All other enable bits are left unchanged.
- R10: rx_dreq_o equals status bit 3 while the receive DMA enable is set and is low otherwise. tx_dreq_o equals status bit 4 while the transmit DMA enable is set and is low otherwise.
- R11: Writes to offsets 0x2 and 0x4 leave status, enable and DMA control unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| evt_set | input | 16 | Event set pulses, one per status position |
| bus_busy | input | 1 | Live bus-busy flag, shown in status bit 12 |
| irq_o | output | 1 | Combined interrupt |
| rx_dreq_o | output | 1 | Receive DMA request |
| tx_dreq_o | output | 1 | Transmit DMA request |

## Verification
Any wrong stored status, enable or DMA bit shows up in the cycle after the edge that corrupted it, because irq_o and both DMA requests are decoded straight from the registers. A register readback then shows the same fault one edge after its read strobe. A vector priority or clear fault shows in the next vector read. A fault that clears the wrong bit also shows in the status readback that follows, or in the vector code after that. Sweeping every enable mask against every combination of the low status flags exposes each priority slot and each clear position separately.

// File: rtl/isv_pkg.sv
package isv_pkg;

    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 4;
    localparam int EN_W     = 5;
    localparam int CODE_W   = $clog2(EN_W + 1);

    localparam int BIT_NOACK  = 1;
    localparam int BIT_ARDY   = 2;
    localparam int BIT_RXRDY  = 3;
    localparam int BIT_TXRDY  = 4;
    localparam int BIT_SLAVE  = 9;
    localparam int BIT_TXUND  = 10;
    localparam int BIT_RXOVR  = 11;
    localparam int BIT_BUSY   = 12;
    localparam int BIT_SBYTE  = 15;

    localparam int BIT_RXDMA  = 15;
    localparam int BIT_TXDMA  = 7;

    localparam logic [DATA_W-1:0] STAT_KEEP =
        (DATA_W'(1) << BIT_NOACK) | (DATA_W'(1) << BIT_ARDY)  |
        (DATA_W'(1) << BIT_RXRDY) | (DATA_W'(1) << BIT_TXRDY) |
        (DATA_W'(1) << BIT_SLAVE) | (DATA_W'(1) << BIT_TXUND) |
        (DATA_W'(1) << BIT_RXOVR) | (DATA_W'(1) << BIT_SBYTE);

    localparam logic [DATA_W-1:0] DMA_KEEP =
        (DATA_W'(1) << BIT_RXDMA) | (DATA_W'(1) << BIT_TXDMA);

    typedef enum logic [ADDR_W-1:0] {
        OFS_ENABLE = 4'h0,
        OFS_STATUS = 4'h2,
        OFS_VECTOR = 4'h4,
        OFS_DMA    = 4'h6
    } reg_ofs_e;

    typedef struct packed {
        logic wr_enable;
        logic wr_dma;
        logic rd_any;
        logic rd_enable;
        logic rd_status;
        logic rd_vector;
        logic rd_dma;
    } bus_dec_t;

    typedef struct packed {
        logic [DATA_W-1:0] dma;
        logic [EN_W-1:0]   en;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] widen_en(input logic [EN_W-1:0] v);
        return DATA_W'(v);
    endfunction

endpackage

// File: rtl/isv_busdec.sv
module isv_busdec
    import isv_pkg::*;
(
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    output bus_dec_t          dec
);
    always_comb begin
        dec        = '0;
        dec.rd_any = rd;
        unique case (addr)
            OFS_ENABLE: begin
                dec.wr_enable = wr;
                dec.rd_enable = rd;
            end
            OFS_STATUS: dec.rd_status = rd;
            OFS_VECTOR: dec.rd_vector = rd;
            OFS_DMA: begin
                dec.wr_dma = wr;
                dec.rd_dma = rd;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/isv_prio.sv
module isv_prio #(
    parameter int W      = 5,
    parameter int CODE_W = $clog2(W + 1)
) (
    input  logic [W-1:0]      pend,
    output logic [W-1:0]      first,
    output logic [CODE_W-1:0] code
);
    logic [W:0] seen;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_chain
        assign first[i]  = pend[i] & ~seen[i];
        assign seen[i+1] = seen[i] | pend[i];
    end

    always_comb begin
        code = '0;
        for (int i = 0; i < W; i++) begin
            if (first[i]) code = CODE_W'(i + 1);
        end
    end
endmodule

// File: rtl/isv_ctrl.sv
module isv_ctrl
    import isv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_enable,
    input  logic              wr_dma,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl_q
);
    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_enable) ctrl_d.en = wdata[EN_W-1:0];
        if (wr_dma) begin
            ctrl_d.dma = wdata & DMA_KEEP;
            if (wdata[BIT_RXDMA]) ctrl_d.en[BIT_RXRDY] = 1'b0;
            if (wdata[BIT_TXDMA]) ctrl_d.en[BIT_TXRDY] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end
endmodule

// File: rtl/isv_status.sv
module isv_status
    import isv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] set_pulse,
    input  logic [DATA_W-1:0] clr_pulse,
    output logic [DATA_W-1:0] stat_q
);
    logic [DATA_W-1:0] stat_d;

    always_comb stat_d = (stat_q & ~clr_pulse) | (set_pulse & STAT_KEEP);

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_d;
    end
endmodule

// File: rtl/irq_status_vector.sv
module irq_status_vector
    import isv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] evt_set,
    input  logic              bus_busy,
    output logic              irq_o,
    output logic              rx_dreq_o,
    output logic              tx_dreq_o
);
    bus_dec_t          dec;
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] stat_q;
    logic [EN_W-1:0]   pend;
    logic [EN_W-1:0]   first;
    logic [CODE_W-1:0] code;
    logic [DATA_W-1:0] clr_pulse;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    isv_busdec u_dec (
        .wr   (bus_wr),
        .rd   (bus_rd),
        .addr (bus_addr),
        .dec  (dec)
    );

    isv_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_enable (dec.wr_enable),
        .wr_dma    (dec.wr_dma),
        .wdata     (bus_wdata),
        .ctrl_q    (ctrl_q)
    );

    assign pend = stat_q[EN_W-1:0] & ctrl_q.en;

    isv_prio #(.W(EN_W), .CODE_W(CODE_W)) u_prio (
        .pend  (pend),
        .first (first),
        .code  (code)
    );

    assign clr_pulse = dec.rd_vector ? widen_en(first) : '0;

    isv_status u_stat (
        .clk       (clk),
        .rst       (rst),
        .set_pulse (evt_set),
        .clr_pulse (clr_pulse),
        .stat_q    (stat_q)
    );

    always_comb begin
        rd_mux = '0;
        if (dec.rd_enable) rd_mux = widen_en(ctrl_q.en);
        if (dec.rd_status) begin
            rd_mux           = stat_q;
            rd_mux[BIT_BUSY] = bus_busy;
        end
        if (dec.rd_vector) rd_mux = DATA_W'(code);
        if (dec.rd_dma)    rd_mux = ctrl_q.dma;
    end

    always_ff @(posedge clk) begin
        if (rst)             rdata_q <= '0;
        else if (dec.rd_any) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign irq_o     = |pend;
    assign rx_dreq_o = ctrl_q.dma[BIT_RXDMA] & stat_q[BIT_RXRDY];
    assign tx_dreq_o = ctrl_q.dma[BIT_TXDMA] & stat_q[BIT_TXRDY];
endmodule

// File: rtl/isv_checker.sv
module isv_checker
    import isv_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] evt_set,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] stat,
    input logic              irq_o,
    input logic              rx_dreq_o,
    input logic              tx_dreq_o
);
    logic rd_vec, rd_en, rd_dma, wr_ignored;
    assign rd_vec     = bus_rd && (bus_addr == OFS_VECTOR);
    assign rd_en      = bus_rd && (bus_addr == OFS_ENABLE);
    assign rd_dma     = bus_rd && (bus_addr == OFS_DMA);
    assign wr_ignored = bus_wr && (bus_addr == OFS_STATUS || bus_addr == OFS_VECTOR);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!irq_o && !rx_dreq_o && !tx_dreq_o && bus_rdata == '0)); // R1

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_vec |=> (($past(stat) & ~stat) == '0)); // R2

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        ((evt_set & STAT_KEEP) != '0) |=> (($past(evt_set) & STAT_KEEP & ~stat) == '0)); // R7

    AST_EN_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (bus_rdata[DATA_W-1:EN_W] == '0)); // R4

    AST_VEC_CODE_LIVE: assert property (@(posedge clk) disable iff (rst)
        (rd_vec && irq_o) |=> (bus_rdata != '0)); // R6

    AST_VEC_CODE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (rd_vec && !irq_o) |=> (bus_rdata == '0)); // R6

    AST_DMA_BITS_ONLY: assert property (@(posedge clk) disable iff (rst)
        rd_dma |=> ((bus_rdata & ~DMA_KEEP) == '0)); // R8

    AST_RX_DREQ_SRC: assert property (@(posedge clk) disable iff (rst)
        rx_dreq_o |-> stat[BIT_RXRDY]); // R10

    AST_TX_DREQ_SRC: assert property (@(posedge clk) disable iff (rst)
        tx_dreq_o |-> stat[BIT_TXRDY]); // R10

    AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_ignored && !bus_rd && evt_set == '0) |=> $stable(stat)); // R11
endmodule

bind irq_status_vector isv_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .evt_set   (evt_set),
    .bus_rdata (bus_rdata),
    .stat      (stat_q),
    .irq_o     (irq_o),
    .rx_dreq_o (rx_dreq_o),
    .tx_dreq_o (tx_dreq_o)
);

// File: tb/irq_status_vector_bench.sv
`timescale 1ns/1ps
module irq_status_vector_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] evt_set = '0;
    logic        bus_busy = 1'b0;
    logic        irq_o, rx_dreq_o, tx_dreq_o;

    int n_vec = 0;
    int n_bad = 0;

    logic [15:0] m_stat;
    logic [4:0]  m_en;
    logic [15:0] m_dma;

    localparam logic [15:0] KEEP = 16'h8E1E;

    always #10 clk = ~clk;

    irq_status_vector u_irq_status_vector (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_set(evt_set), .bus_busy(bus_busy), .irq_o(irq_o),
        .rx_dreq_o(rx_dreq_o), .tx_dreq_o(tx_dreq_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_code();
        for (int i = 0; i < 5; i++)
            if (m_stat[i] && m_en[i]) return 16'(i + 1);
        return 16'd0;
    endfunction

    task automatic cycle(input logic w, input logic r, input logic [3:0] a,
                         input logic [15:0] d, input logic [15:0] e);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; evt_set = e;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; evt_set = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_stat = '0; m_en = '0; m_dma = '0;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        cycle(1'b1, 1'b0, a, d, '0);
        if (a == 4'h0) m_en = d[4:0];
        if (a == 4'h6) begin
            m_dma = d & 16'h8080;
            if (d[15]) m_en[3] = 1'b0;
            if (d[7])  m_en[4] = 1'b0;
        end
    endtask

    task automatic pulse(input logic [15:0] e);
        cycle(1'b0, 1'b0, 4'h0, '0, e);
        m_stat = m_stat | (e & KEEP);
    endtask

    task automatic bus_read(input logic [3:0] a, input string tag);
        logic [15:0] exp;
        logic [15:0] code;
        exp = '0;
        case (a)
            4'h0: exp = {11'd0, m_en};
            4'h2: begin exp = m_stat; exp[12] = bus_busy; end
            4'h4: begin
                code = exp_code();
                exp  = code;
                if (code != 0) m_stat[code - 1] = 1'b0;
            end
            4'h6: exp = m_dma;
            default: exp = '0;
        endcase
        cycle(1'b0, 1'b1, a, '0, '0);
        chk(tag, bus_rdata, exp);
    endtask

    task automatic chk_outs(input string tag);
        chk({tag, " irq"}, {15'd0, irq_o}, {15'd0, |(m_stat[4:0] & m_en)});
        chk({tag, " rxdreq"}, {15'd0, rx_dreq_o}, {15'd0, m_dma[15] & m_stat[3]});
        chk({tag, " txdreq"}, {15'd0, tx_dreq_o}, {15'd0, m_dma[7] & m_stat[4]});
    endtask

    initial begin
        #4000000;
        n_vec++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        m_stat = '0; m_en = '0; m_dma = '0;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports and in every readback
        chk("R1 rdata", bus_rdata, 16'h0);
        chk_outs("R1");
        rst = 1'b0;
        bus_read(4'h0, "R1 enable");
        bus_read(4'h2, "R1 status");
        bus_read(4'h6, "R1 dma");

        // R2: each single position, only kept ones stick
        for (int k = 0; k < 16; k++) begin
            do_reset();
            pulse(16'(1) << k);
            bus_read(4'h2, "R2 single");
            bus_read(4'h2, "R2 sticky");
        end
        // R3: busy shown live in bit 12, status read clears nothing
        do_reset();
        pulse(16'hFFFF);
        bus_busy = 1'b1;
        bus_read(4'h2, "R3 busy");
        bus_busy = 1'b0;
        bus_read(4'h2, "R3 nobusy");
        bus_read(4'h8, "R3 unmapped");

        // R4 R5 R6: every low status pattern against every enable mask
        for (int p = 0; p < 16; p++) begin
            for (int e = 0; e < 32; e++) begin
                do_reset();
                pulse(16'(p) << 1);
                bus_write(4'h0, 16'(e) | 16'hFFE0);
                bus_read(4'h0, "R4 enable");
                chk_outs("R5");
                for (int n = 0; n < 5; n++) begin
                    bus_read(4'h4, "R6 vector");
                    chk_outs("R5 after R6");
                end
                bus_read(4'h2, "R6 status");
            end
        end

        // R8 R9 R10: DMA enable combinations with junk bits
        for (int d = 0; d < 4; d++) begin
            do_reset();
            bus_write(4'h0, 16'h001F);
            pulse(16'h0018);
            bus_write(4'h6, 16'h7F7F | (d[1] ? 16'h8000 : 16'h0) | (d[0] ? 16'h0080 : 16'h0));
            bus_read(4'h6, "R8 dma");
            bus_read(4'h0, "R9 enable");
            chk_outs("R10");
            bus_read(4'h4, "R10 vector");
            chk_outs("R10 cleared");
            bus_write(4'h0, 16'h001F);
            bus_read(4'h4, "R10 vector2");
            bus_read(4'h4, "R10 vector3");
            chk_outs("R10 drained");
        end

        // R11: writes to status and vector offsets are ignored
        do_reset();
        bus_write(4'h0, 16'h0015);
        bus_write(4'h6, 16'h0080);
        pulse(16'h0804);
        bus_write(4'h2, 16'hFFFF);
        bus_write(4'h4, 16'h0000);
        bus_write(4'h4, 16'hFFFF);
        bus_read(4'h2, "R11 status");
        bus_read(4'h0, "R11 enable");
        bus_read(4'h6, "R11 dma");
        chk_outs("R11");

        // R7: set and vector clear on the same bit in one cycle
        do_reset();
        bus_write(4'h0, 16'h0004);
        pulse(16'h0004);
        cycle(1'b0, 1'b1, 4'h4, '0, 16'h0004);
        chk("R7 code", bus_rdata, 16'h0003);
        bus_read(4'h2, "R7 status");
        chk_outs("R7");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule